// File: doc/BRIEF.md
# Video Frame Size Monitor

This block watches the three qualifier signals of a parallel camera video stream: frame valid, line valid and pixel (data) valid. From them it measures how many pixels each line carries and how many lines each frame carries. It keeps the most recent per-line pixel count and per-frame line count as raw capture registers. It also reports a settled width and height, and it raises a one-cycle pulse whenever a completed frame's size differs from the size it last reported.

The stream is push-only: a camera cannot be stalled, so there is no ready signal and no back-pressure. Every cycle in which line valid and data valid are both high counts as one pixel. Edges of line valid and frame valid are found by comparing each input with a registered copy of itself, sampled on the pixel clock. The line count is captured from a counter that increments when a line ends. When the frame and its last line end in the same cycle, the captured count lacks that final line, so the reported height adds one.

Top module: `frame_size_mon`

## Requirements
- R1: The pixel counter counts the cycles in which `lval` and `dval` are both high. A `dval` seen while `lval` is low has no effect on the count.
- R2: In the cycle after `lval` is sampled falling, `last_x` holds the pixel count of the line that just ended. This happens for every line, including lines in the middle of a frame.
- R3: A line ends when `lval` is sampled falling while `fval` was high in the previous cycle, and each line end increments the line counter. On a sampled `fval` fall, `last_y` takes the counter value from before any line end in that same cycle. So a frame whose last line ends together with `fval` gives lines-1, and a frame where `fval` falls later gives the full line count.
- R4: `width` equals `last_x` and `height` equals `last_y`+1, saturating at all ones. Both update only in the cycle in which `size_chg` is high.
- R5: `size_chg` is high for exactly one cycle, starting two clock edges after the edge that samples `fval` low. It is raised when the captured pair differs from the stored pair, or when this is the first frame since reset. The stored pair then takes the captured values.
- R6: A frame with the same captured size as the stored pair raises no `size_chg`, and `width` and `height` stay unchanged.
- R7: The pixel and line counters saturate at 2^W-1 and never wrap.
- R8: Synchronous `rst` clears `last_x`, `last_y`, `width`, `height` and `size_chg` to 0 and forgets the stored pair.
- R9: The pixel counter restarts at each rising `lval`, and the line counter restarts at each rising `fval`, so no count carries over between lines or frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fval | input | 1 | Frame valid qualifier |
| lval | input | 1 | Line valid qualifier |
| dval | input | 1 | Pixel valid qualifier |
| last_x | output | W | Pixel count captured at the most recent line end |
| last_y | output | W | Line count captured at the most recent frame end |
| width | output | W | Reported frame width |
| height | output | W | Reported frame height (captured line count plus one) |
| size_chg | output | 1 | One-cycle pulse on a change of reported size |

## Verification
The assertions assume that `fval` stays high for at least two cycles and stays low for at least two cycles between frames. They also assume that `rst` is held high from time zero, so that every `$past` value is defined. The stimulus drives all inputs at the falling clock edge. It opens each frame with two cycles of `fval` alone, and it keeps `lval` low for at least one cycle between lines. It closes each frame either with `fval` and `lval` falling together or with `fval` falling two cycles after the last line, and it follows every frame with idle cycles. Stray `dval` pulses appear only while `lval` is low.

// File: rtl/fsm_pkg.sv
package fsm_pkg;
  // rise/fall strobes of a qualifier seen on the pixel clock
  typedef struct packed {
    logic rise;
    logic fall;
    logic prev;
  } edge_t;
endpackage

// File: rtl/fsm_edge.sv
module fsm_edge
  import fsm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sig,
  output edge_t ev
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig;
  end

  always_comb begin
    ev.rise = sig & ~sig_q;
    ev.fall = ~sig & sig_q;
    ev.prev = sig_q;
  end
endmodule

// File: rtl/fsm_sat_cnt.sv
module fsm_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         seed,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (clr)                cnt <= W'(seed);
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fsm_size_cmp.sv
module fsm_size_cmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] cap_x,
  input  logic [W-1:0] cap_y,
  output logic [W-1:0] width,
  output logic [W-1:0] height,
  output logic         size_chg
);
  localparam logic [W-1:0] TOP = '1;

  logic         known;
  logic [W-1:0] st_y;
  logic         differs;

  assign differs = !known || (cap_x != width) || (cap_y != st_y);

  always_ff @(posedge clk) begin
    if (rst) begin
      known    <= 1'b0;
      st_y     <= '0;
      width    <= '0;
      height   <= '0;
      size_chg <= 1'b0;
    end else begin
      size_chg <= 1'b0;
      if (cap && differs) begin
        known    <= 1'b1;
        st_y     <= cap_y;
        width    <= cap_x;
        height   <= (cap_y == TOP) ? TOP : cap_y + 1'b1;
        size_chg <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_size_mon.sv
module frame_size_mon
  import fsm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fval,
  input  logic         lval,
  input  logic         dval,
  output logic [W-1:0] last_x,
  output logic [W-1:0] last_y,
  output logic [W-1:0] width,
  output logic [W-1:0] height,
  output logic         size_chg
);
  edge_t        fe, le;
  logic [W-1:0] x_cnt, y_cnt;
  logic         line_end;
  logic         cap_q;

  fsm_edge u_fe (.clk(clk), .rst(rst), .sig(fval), .ev(fe));
  fsm_edge u_le (.clk(clk), .rst(rst), .sig(lval), .ev(le));

  assign line_end = le.fall & fe.prev;

  // pixels in the current line; first pixel may coincide with lval rise
  fsm_sat_cnt #(.W(W)) u_xcnt (
    .clk(clk), .rst(rst),
    .clr(le.rise), .seed(dval),
    .inc(lval & dval),
    .cnt(x_cnt)
  );

  // completed lines in the current frame
  fsm_sat_cnt #(.W(W)) u_ycnt (
    .clk(clk), .rst(rst),
    .clr(fe.rise), .seed(1'b0),
    .inc(line_end),
    .cnt(y_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_x <= '0;
      last_y <= '0;
      cap_q  <= 1'b0;
    end else begin
      cap_q <= fe.fall;
      if (le.fall) last_x <= x_cnt;
      if (fe.fall) last_y <= y_cnt;
    end
  end

  fsm_size_cmp #(.W(W)) u_cmp (
    .clk(clk), .rst(rst),
    .cap(cap_q),
    .cap_x(last_x), .cap_y(last_y),
    .width(width), .height(height),
    .size_chg(size_chg)
  );
endmodule

// File: rtl/fsm_chk.sv
module fsm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         fval,
  input logic         lval,
  input logic [W-1:0] last_x,
  input logic [W-1:0] last_y,
  input logic [W-1:0] width,
  input logic [W-1:0] height,
  input logic         size_chg
);
  localparam logic [W-1:0] TOP = '1;

  // R5
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    size_chg |=> !size_chg);

  // R5
  pulse_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    size_chg |-> ($past(fval, 3) && !$past(fval, 2)));

  // R4
  size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(width) || !$stable(height)) |-> size_chg);

  // R4
  size_value_chk: assert property (@(posedge clk) disable iff (rst)
    size_chg |-> (width == last_x &&
                  height == ((last_y == TOP) ? TOP : last_y + 1'b1)));

  // R2
  x_capture_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(last_x) |-> (!$past(lval) && $past(lval, 2)));

  // R3
  y_capture_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(last_y) |-> (!$past(fval) && $past(fval, 2)));
endmodule

bind frame_size_mon fsm_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .fval(fval), .lval(lval),
  .last_x(last_x), .last_y(last_y),
  .width(width), .height(height), .size_chg(size_chg)
);

// File: tb/sim_frame_size_mon.sv
`timescale 1ns/1ps
module sim_frame_size_mon;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fval = 1'b0, lval = 1'b0, dval = 1'b0;
  logic [W-1:0] last_x, last_y, width, height;
  logic size_chg;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  frame_size_mon #(.W(W)) u0 (
    .clk(clk), .rst(rst), .fval(fval), .lval(lval), .dval(dval),
    .last_x(last_x), .last_y(last_y), .width(width), .height(height),
    .size_chg(size_chg)
  );

  always @(negedge clk) if (!rst && size_chg) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit f, input bit l, input bit d);
    @(negedge clk);
    fval = f; lval = l; dval = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  // one line of px pixels; gapped inserts an idle cycle after each pixel
  task automatic line(input int px, input bit gapped);
    for (int i = 0; i < px; i++) begin
      drive(1, 1, 1);
      if (gapped) drive(1, 1, 0);
    end
  endtask

  task automatic frame(input int lines, input int px, input bit gapped,
                       input bit stray, input bit late);
    drive(1, 0, 0); drive(1, 0, 0);
    for (int k = 0; k < lines; k++) begin
      line(px, gapped);
      if (k < lines - 1) begin
        drive(1, 0, stray); drive(1, 0, stray);
      end
    end
    if (late) begin
      drive(1, 0, 0); drive(1, 0, 0);
    end
    drive(0, 0, 0);
    idle(4);
  endtask

  task automatic check_size(input string req, input int x, input int y,
                            input int w, input int h, input int np);
    chk({req, " last_x"}, int'(last_x), x);
    chk({req, " last_y"}, int'(last_y), y);
    chk({req, " width"},  int'(width),  w);
    chk({req, " height"}, int'(height), h);
    chk({req, " pulses"}, pulses, np);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8 reset last_x", int'(last_x), 0);
    chk("R8 reset last_y", int'(last_y), 0);
    chk("R8 reset width", int'(width), 0);
    chk("R8 reset height", int'(height), 0);
    chk("R8 reset size_chg", int'(size_chg), 0);
  endtask

  task automatic t_first_frame;
    pulses = 0;
    frame(4, 5, 0, 0, 0);
    check_size("R3 R4 R5 first", 5, 3, 5, 4, 1);
  endtask

  task automatic t_same_again;
    pulses = 0;
    frame(4, 5, 0, 0, 0);
    check_size("R6 R9 repeat", 5, 3, 5, 4, 0);
  endtask

  task automatic t_gapped;
    pulses = 0;
    frame(4, 7, 1, 0, 0);
    check_size("R1 R5 gapped", 7, 3, 7, 4, 1);
  endtask

  task automatic t_stray_dval;
    pulses = 0;
    frame(4, 7, 0, 1, 0);
    check_size("R1 R6 stray dval", 7, 3, 7, 4, 0);
  endtask

  task automatic t_late_fval;
    pulses = 0;
    frame(3, 6, 0, 0, 1);
    check_size("R3 late fval", 6, 3, 6, 4, 1);
  endtask

  task automatic t_mid_line;
    pulses = 0;
    drive(1, 0, 0); drive(1, 0, 0);
    line(9, 0);
    drive(1, 0, 0);
    @(negedge clk);
    chk("R2 mid-frame last_x", int'(last_x), 9);
    chk("R2 mid-frame last_y held", int'(last_y), 3);
    fval = 1; lval = 0; dval = 0;
    line(9, 0);
    drive(0, 0, 0);
    idle(4);
    check_size("R2 R4 two lines", 9, 1, 9, 2, 1);
  endtask

  task automatic t_reset_mid;
    drive(1, 0, 0); drive(1, 1, 1); drive(1, 1, 1);
    rst = 1'b1;
    drive(0, 0, 0);
    drive(0, 0, 0);
    chk("R8 mid reset last_x", int'(last_x), 0);
    chk("R8 mid reset width", int'(width), 0);
    chk("R8 mid reset height", int'(height), 0);
    rst = 1'b0;
    idle(2);
    pulses = 0;
    frame(2, 9, 0, 0, 0);
    check_size("R8 R5 first after reset", 9, 1, 9, 2, 1);
  endtask

  task automatic t_saturate;
    pulses = 0;
    frame(1, 70000, 0, 0, 0);
    check_size("R7 saturate", 65535, 0, 65535, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(2);
    t_first_frame();
    t_same_again();
    t_gapped();
    t_stray_dval();
    t_late_fval();
    t_mid_line();
    t_reset_mid();
    t_saturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule